// File: doc/BRIEF.md
# Monitor Channel Message Transmitter

This block sends a short control message, one byte at a time, over the monitor sub-channel of a frame-based serial control interface. A message is first loaded into a small internal buffer through a valid/ready byte interface with an end flag. The block then drives each byte into the monitor slot of every frame and raises a per-frame transmit-enable bit. It moves on only after the far end has confirmed the byte through a per-frame, active-low acknowledge bit. That confirmation has two steps: a pre-acknowledge first, then a full acknowledge.

After the last byte is confirmed, the block withdraws the enable bit and sends an idle slot to mark the end of the message. It then waits for a closing acknowledge and reports completion. If the far end withholds the acknowledge after pre-acknowledging a byte, the block treats this as an abort. It sends one idle frame and restarts the whole message from its first byte. An optional timer supervises the wait for each pre-acknowledge. When it expires, the block sets a sticky error and drops back to idle.

Top module: `mon_tx`

## Requirements
- R1: After reset, `mon_en` is 0, `mon_byte` is all ones (0xFF), `done`, `aborted` and `timeout` are 0, and `msg_ready` is 1.
- R2: `msg_ready` is 1 only while no message is in flight. Bytes are stored in order until one arrives with `msg_last` = 1, or until the byte that fills slot DEPTH-1 arrives, which ends the message even without `msg_last`. The first byte goes into the slot at the next `frame_stb`.
- R3: Each byte stays in `mon_byte` with `mon_en` = 1 for at least two consecutive frames. The acknowledge value sampled at the end of a byte's first frame is ignored.
- R4: `ack_n` is sampled in `frame_stb` cycles. Once a byte has filled two frames, `ack_n` = 0 counts as its pre-acknowledge. The full acknowledge is `ack_n` = 1 at the next strobe followed by `ack_n` = 0 at the one after it. The next byte then appears from that strobe onward, and bytes go out in load order.
- R5: When the last byte is fully acknowledged, the slot becomes 0xFF with `mon_en` = 0 from that strobe onward. A later strobe with `ack_n` = 0 pulses `done` for one cycle and returns the block to idle.
- R6: After a pre-acknowledge, `ack_n` = 1 at two consecutive strobes is an abort. `aborted` pulses for one cycle, one idle frame (0xFF, `mon_en` = 0) follows, and the message is then sent again from its first byte.
- R7: With `timer_en` = 1, a byte that is not pre-acknowledged within TIMEOUT_CYCLES clock cycles of its start sets `timeout`. Transmission stops (`mon_en` = 0, slot 0xFF) and `msg_ready` returns to 1.
- R8: With `timer_en` = 0, `timeout` never rises, however long the pre-acknowledge is delayed.
- R9: `timeout` stays set until the first byte of a new message is accepted, which clears it.
- R10: `mon_byte` and `mon_en` change only in `frame_stb` cycles or in the cycle a timeout is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| ack_n | input | 1 | Received acknowledge bit of the frame just ended, active low |
| timer_en | input | 1 | Enables the pre-acknowledge timeout |
| msg_data | input | DATA_W | Message byte offered for loading |
| msg_last | input | 1 | Marks the offered byte as the last of its message |
| msg_valid | input | 1 | Offered byte is valid |
| msg_ready | output | 1 | Block accepts a byte in this cycle |
| mon_byte | output | DATA_W | Monitor slot contents for the current frame |
| mon_en | output | 1 | Transmit-enable bit for the current frame |
| done | output | 1 | One-cycle pulse on the closing acknowledge |
| aborted | output | 1 | One-cycle pulse when an abort is recognised |
| timeout | output | 1 | Sticky pre-acknowledge timeout flag |

## Verification
A wrong byte index or buffer pointer shows up at the slot within one frame of the affected byte: the byte comes out in the wrong order or repeated, and a receiver model comparing against the loaded message catches it. Handshake counting errors take longer to appear. Miscounting the high frames of the acknowledge either advances a byte early or turns a normal acknowledge into an abort, which the `aborted` pulse and a duplicated byte stream expose within four frames. A timer fault only shows after the full timeout window, as a missing or premature `timeout`. For that reason the bench samples `timeout` well before and well after the expected expiry.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ARM,
    ST_PRE,
    ST_ACK,
    ST_EOM
  } mtx_state_e;

endpackage

// File: rtl/mon_tx_msgbuf.sv
module mon_tx_msgbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [IW-1:0]     wr_ptr,
  output logic              slot_last
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IW-1:0]     ptr_d;

  always_comb begin
    ptr_d = wr_ptr;
    if (wr_en) begin
      if (wr_end) ptr_d = '0;
      else        ptr_d = wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data   = mem[rd_idx];
  assign slot_last = (wr_ptr == IW'(DEPTH - 1));

endmodule

// File: rtl/mon_tx_timer.sv
module mon_tx_timer #(
  parameter int LIMIT = 24000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                            cnt_d = '0;
    else if (run && (cnt_q != CW'(LIMIT)))  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == CW'(LIMIT));

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_tx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int DEPTH          = 8,
  parameter int TIMEOUT_CYCLES = 24000,
  localparam int IW            = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              ack_n,
  input  logic              timer_en,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              msg_last,
  input  logic              msg_valid,
  output logic              msg_ready,
  output logic [DATA_W-1:0] mon_byte,
  output logic              mon_en,
  output logic              done,
  output logic              aborted,
  output logic              timeout
);

  localparam logic [DATA_W-1:0] IDLE_W = '1;

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  mtx_state_e        state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d, len_q, len_d, rd_idx, wr_ptr;
  logic              rep_q, rep_d, hi_q, hi_d;
  logic [DATA_W-1:0] byte_q, byte_d, rd_data;
  logic              en_q, en_d, done_q, done_d, abrt_q, abrt_d, to_q, to_d;
  logic              acc, msg_end, slot_last, tmr_restart, tmr_run, tmr_exp;

  assign msg_ready = (state_q == ST_IDLE) || (state_q == ST_LOAD);
  assign acc       = msg_valid && msg_ready;
  assign msg_end   = msg_last || slot_last;
  assign rd_idx    = (state_q == ST_ACK) ? idx_q + 1'b1 : '0;
  assign tmr_run   = (state_q == ST_PRE) && timer_en;

  mon_tx_msgbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) buf_i (
    .clk(clk), .rst_n(rst_s), .wr_en(acc), .wr_end(msg_end),
    .wr_data(msg_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .slot_last(slot_last)
  );

  mon_tx_timer #(.LIMIT(TIMEOUT_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_s), .restart(tmr_restart),
    .run(tmr_run), .expired(tmr_exp)
  );

  always_comb begin
    state_d = state_q; idx_d = idx_q; len_d = len_q;
    rep_d = rep_q; hi_d = hi_q; byte_d = byte_q; en_d = en_q;
    to_d = to_q; done_d = 1'b0; abrt_d = 1'b0; tmr_restart = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_LOAD: begin
        if (acc) begin
          if (state_q == ST_IDLE) to_d = 1'b0;
          if (msg_end) begin
            len_d   = wr_ptr;
            state_d = ST_ARM;
          end else begin
            state_d = ST_LOAD;
          end
        end
      end
      ST_ARM: begin
        if (frame_stb) begin
          idx_d = '0; byte_d = rd_data; en_d = 1'b1;
          rep_d = 1'b0; tmr_restart = 1'b1; state_d = ST_PRE;
        end
      end
      ST_PRE: begin
        if (tmr_exp) begin
          to_d = 1'b1; en_d = 1'b0; byte_d = IDLE_W; state_d = ST_IDLE;
        end else if (frame_stb) begin
          if (!rep_q) rep_d = 1'b1;
          else if (!ack_n) begin
            hi_d = 1'b0; state_d = ST_ACK;
          end
        end
      end
      ST_ACK: begin
        if (frame_stb) begin
          if (ack_n) begin
            if (hi_q) begin
              abrt_d = 1'b1; en_d = 1'b0; byte_d = IDLE_W; state_d = ST_ARM;
            end else begin
              hi_d = 1'b1;
            end
          end else if (hi_q) begin
            if (idx_q == len_q) begin
              en_d = 1'b0; byte_d = IDLE_W; state_d = ST_EOM;
            end else begin
              idx_d = idx_q + 1'b1; byte_d = rd_data; rep_d = 1'b0;
              tmr_restart = 1'b1; state_d = ST_PRE;
            end
          end
        end
      end
      ST_EOM: begin
        if (frame_stb && !ack_n) begin
          done_d = 1'b1; state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE; idx_q <= '0; len_q <= '0; rep_q <= 1'b0;
      hi_q <= 1'b0; byte_q <= IDLE_W; en_q <= 1'b0; done_q <= 1'b0;
      abrt_q <= 1'b0; to_q <= 1'b0;
    end else begin
      state_q <= state_d; idx_q <= idx_d; len_q <= len_d; rep_q <= rep_d;
      hi_q <= hi_d; byte_q <= byte_d; en_q <= en_d; done_q <= done_d;
      abrt_q <= abrt_d; to_q <= to_d;
    end
  end

  assign mon_byte = byte_q;
  assign mon_en   = en_q;
  assign done     = done_q;
  assign aborted  = abrt_q;
  assign timeout  = to_q;

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_s)
    msg_ready |-> !mon_en);

  assert_done_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (!mon_en && $past(frame_stb) && !$past(ack_n)));

  assert_abort_idles_slot_R6: assert property (@(posedge clk) disable iff (!rst_s)
    aborted |-> (!mon_en && (mon_byte == IDLE_W)));

  assert_no_timeout_disabled_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !timer_en |=> !$rose(timeout));

  assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (timeout && !acc) |=> timeout);

  assert_slot_frame_aligned_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (!frame_stb && !tmr_exp) |=> ($stable(mon_byte) && $stable(mon_en)));

endmodule

// File: tb/mon_tx_tb_top.sv
module mon_tx_tb_top;

  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int TMO = 200;
  localparam int FP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic ack_n = 1'b1;
  logic timer_en = 1'b1;
  logic [DW-1:0] msg_data = '0;
  logic msg_last = 1'b0;
  logic msg_valid = 1'b0;
  logic msg_ready, mon_en, done, aborted, timeout;
  logic [DW-1:0] mon_byte;

  always #5 clk = ~clk;

  mon_tx #(.DATA_W(DW), .DEPTH(DEPTH), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ack_n(ack_n),
    .timer_en(timer_en), .msg_data(msg_data), .msg_last(msg_last),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .mon_byte(mon_byte),
    .mon_en(mon_en), .done(done), .aborted(aborted), .timeout(timeout)
  );

  int n_tests = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int abrt_cnt = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_q[$];

  // receiver model controls
  bit rx_on = 1'b0;
  bit no_pre = 1'b0;
  bit abort_arm = 1'b0;
  int abort_idx = 0;
  int rstate = 0; // 0 wait, 1 got first, 2 pre-acked, 3 high sent, 4 acked
  int byte_cnt = 0;
  logic [DW-1:0] cur_byte = '0;
  bit r3_checked = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (aborted) abrt_cnt++;
  end

  task automatic rx_step();
    logic [DW-1:0] e;
    if (mon_en) begin
      if (rstate == 0 || rstate == 4) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected byte", int'(mon_byte), 0);
        end else begin
          e = exp_q.pop_front();
          chk(mon_byte == e, "R4 byte order", int'(mon_byte), int'(e));
        end
        cur_byte = mon_byte; ack_n = 1'b1; rstate = 1; r3_checked = 1'b0;
        byte_cnt++;
      end else if (rstate == 1) begin
        if (!r3_checked) begin
          chk(mon_byte == cur_byte, "R3 byte held two frames", int'(mon_byte), int'(cur_byte));
          r3_checked = 1'b1;
        end
        if (no_pre) ack_n = 1'b1;
        else begin ack_n = 1'b0; rstate = 2; end
      end else if (rstate == 2) begin
        ack_n = 1'b1; rstate = 3;
      end else begin
        if (abort_arm && (byte_cnt - 1 == abort_idx)) begin
          ack_n = 1'b1; abort_arm = 1'b0; rstate = 0;
        end else begin
          ack_n = 1'b0; rstate = 4;
        end
      end
    end else begin
      if (rstate == 4) begin
        chk(mon_byte == 8'hFF, "R5 idle slot at end", int'(mon_byte), 8'hFF);
        ack_n = 1'b0;
      end else begin
        ack_n = 1'b1;
      end
      rstate = 0; byte_cnt = 0;
    end
  endtask

  initial begin
    forever begin
      repeat (FP - 1) @(negedge clk);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      if (rx_on) rx_step();
    end
  end

  task automatic load(input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                      input logic [DW-1:0] b2, input logic [DW-1:0] b3,
                      input int n, input bit use_last, input bit push);
    logic [DW-1:0] v[4];
    v[0] = b0; v[1] = b1; v[2] = b2; v[3] = b3;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!msg_ready) @(negedge clk);
      msg_valid = 1'b1; msg_data = v[i];
      msg_last = use_last && (i == n - 1);
      if (push) exp_q.push_back(v[i]);
      @(posedge clk);
    end
    @(negedge clk);
    msg_valid = 1'b0; msg_last = 1'b0;
  endtask

  task automatic wait_done(input int prev, input string req);
    int t = 0;
    while (done_cnt == prev && t < 4000) begin
      @(negedge clk); t++;
    end
    chk(done_cnt == prev + 1, req, done_cnt, prev + 1);
  endtask

  task automatic wait_frames(input int n);
    repeat (n * FP) @(negedge clk);
  endtask

  initial begin
    int d0, a0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!mon_en, "R1 mon_en", mon_en, 0);
    chk(mon_byte == 8'hFF, "R1 mon_byte", mon_byte, 8'hFF);
    chk(!done && !aborted && !timeout, "R1 status", {done, aborted, timeout}, 0);
    chk(msg_ready, "R1 msg_ready", msg_ready, 1);
    rx_on = 1'b1;

    // R2 R4 R5: normal two-byte message
    d0 = done_cnt; a0 = abrt_cnt;
    load(8'hA5, 8'h3C, 8'h00, 8'h00, 2, 1'b1, 1'b1);
    chk(!msg_ready, "R2 busy after load", msg_ready, 0);
    wait_done(d0, "R5 done after two bytes");
    @(negedge clk);
    chk(!mon_en && msg_ready, "R5 idle after done", {mon_en, msg_ready}, 1);
    chk(exp_q.size() == 0, "R4 all bytes sent", exp_q.size(), 0);
    chk(abrt_cnt == a0, "R6 no abort in normal flow", abrt_cnt, a0);

    // R6: abort on second byte then retransmit
    d0 = done_cnt; a0 = abrt_cnt;
    abort_idx = 1; abort_arm = 1'b1;
    load(8'h11, 8'h22, 8'h00, 8'h00, 2, 1'b1, 1'b1);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    wait_done(d0, "R6 done after retransmit");
    chk(abrt_cnt == a0 + 1, "R6 abort seen", abrt_cnt, a0 + 1);
    chk(exp_q.size() == 0, "R6 retransmitted from first byte", exp_q.size(), 0);

    // R2: buffer full ends message without last flag
    d0 = done_cnt;
    load(8'h01, 8'h02, 8'h03, 8'h04, 4, 1'b0, 1'b1);
    wait_done(d0, "R2 full buffer ends message");
    chk(exp_q.size() == 0, "R2 four bytes sent", exp_q.size(), 0);

    // R7: timeout with no pre-acknowledge
    no_pre = 1'b1; timer_en = 1'b1;
    load(8'h5A, 8'h00, 8'h00, 8'h00, 1, 1'b1, 1'b1);
    while (!mon_en) @(negedge clk);
    wait_frames(6);
    chk(!timeout && mon_en, "R7 no early timeout", {timeout, mon_en}, 1);
    wait_frames(14);
    chk(timeout, "R7 timeout set", timeout, 1);
    chk(!mon_en && mon_byte == 8'hFF, "R7 slot idle after timeout", int'(mon_byte), 8'hFF);
    chk(msg_ready, "R7 ready after timeout", msg_ready, 1);
    wait_frames(3);
    chk(timeout, "R9 timeout sticky", timeout, 1);

    // R9: cleared by next message
    no_pre = 1'b0; d0 = done_cnt;
    load(8'h77, 8'h00, 8'h00, 8'h00, 1, 1'b1, 1'b1);
    chk(!timeout, "R9 timeout cleared on load", timeout, 0);
    wait_done(d0, "R9 message after timeout");

    // R8: timer disabled
    no_pre = 1'b1; timer_en = 1'b0; d0 = done_cnt;
    load(8'hC3, 8'h00, 8'h00, 8'h00, 1, 1'b1, 1'b1);
    wait_frames(30);
    chk(!timeout && mon_en, "R8 no timeout when disabled", {timeout, mon_en}, 1);
    chk(mon_byte == 8'hC3, "R10 slot steady while waiting", int'(mon_byte), 8'hC3);
    no_pre = 1'b0;
    wait_done(d0, "R8 completes after late pre-ack");
    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule